// File: doc/BRIEF.md
# Output Queue Interrupt and Status Word Controller

This block sits between the output message store of a host-facing serial port and the host. It counts how many outbound messages are waiting and remembers the length of each, oldest first. From that state it forms a 16-bit control word. The host reads this word on its own, and a copy of it is also appended to every output-queue packet the host reads, so the host learns after each read whether more data is waiting.

The host data interrupt is edge-qualified. It is raised only when the queue goes from holding nothing to holding one message. It is dropped when the host sees the control word, whether through an explicit control-register read or through the copy appended to a packet. When an output-queue read completes, the block compares the host's word count with the size the packet really has, which is the message length plus one status half-word. It then flags an empty-queue read or a short read.

Top module: `oq_status_ctl`

## Requirements
- R1: After reset, `irq`, `err_no_item` and `err_short_read` are 0, and `ctrl_word` is 0 (nothing pending).
- R2: A push accepted while no message is pending sets the interrupt source, and `irq` is 1 in the cycle after the push edge when `irq_en` is 1.
- R3: A push accepted while at least one message is already pending never sets the interrupt source.
- R4: `irq` is 0 whenever `irq_en` is 0. The source stays latched, so setting `irq_en` later shows the pending interrupt.
- R5: A cycle with `ctrl_rd` high clears the interrupt source.
- R6: A cycle with `rd_done` high clears the interrupt source in the same way, because it stands for the appended status copy.
- R7: `ctrl_word[11:0]` holds the length in half-words of the oldest pending message, or 0 when none is pending. `ctrl_word[15:12]` holds the pending count, saturated at 15.
- R8: `ctrl_word[31:16]` is always 0, so a 32-bit access returns zeros in its upper two bytes.
- R9: `rd_done` while nothing is pending pulses `err_no_item` for one cycle and leaves the queue unchanged.
- R10: `rd_done` with `rd_words` less than the oldest length plus one pulses `err_short_read` for one cycle. The message is still removed. A count equal to or above that value raises no error.
- R11: After the queue drains and the interrupt is cleared, a push into the empty queue raises the interrupt again.
- R12: The pending count never exceeds `DEPTH`. A push while full is ignored, and the count and stored lengths are unchanged.
- R13: Messages leave in push order, so the reported length follows the push sequence.
- R14: When a push into an empty queue and a clearing read (`ctrl_rd` or `rd_done`) fall in the same cycle, the interrupt source is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_en | input | 1 | Data interrupt enable from configuration |
| push_valid | input | 1 | A new output message has been stored |
| push_len | input | LEN_W | Length of that message in half-words |
| rd_done | input | 1 | Host finished an output-queue read |
| rd_words | input | LEN_W+1 | Half-words the host read, status included |
| ctrl_rd | input | 1 | Explicit host read of the control register |
| irq | output | 1 | Host data interrupt |
| ctrl_word | output | 32 | Control word, upper half zero |
| err_no_item | output | 1 | One-cycle pulse: read with nothing pending |
| err_short_read | output | 1 | One-cycle pulse: read shorter than length plus one |

## Verification
The assertions assume that `push_len` stays within LEN_W bits and that each strobe is a single-cycle pulse tied to one host transaction. They also assume `rd_words` counts the appended status half-word. The bench drives all strobes for exactly one cycle from a bench-side queue model. It keeps lengths and word counts inside their port widths, and it runs a pseudo-random sweep that mixes pushes, reads and control reads, including pushes into a full queue and reads of an empty one.

// File: rtl/oq_status_pkg.sv
`timescale 1ns/1ps
package oq_status_pkg;
   localparam int CTRL_W = 16;   // width of the status word seen by the host
   localparam int BUS_W  = 32;   // widest host access

   typedef struct packed {
      logic none;       // read with nothing pending
      logic short_rd;   // read shorter than length plus one
   } oq_rd_err_t;
endpackage

// File: rtl/oq_len_fifo.sv
`timescale 1ns/1ps
module oq_len_fifo #(
   parameter int DEPTH = 4,
   parameter int LEN_W = 12,
   localparam int CNT_W = $clog2(DEPTH + 1),
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [LEN_W-1:0] push_len,
   input  logic             pop,
   output logic             push_acc,
   output logic [LEN_W-1:0] head_len,
   output logic [CNT_W-1:0] count,
   output logic             empty
);
   logic [LEN_W-1:0] slot [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic             full, pop_acc;

   function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   assign empty    = (count == '0);
   assign full     = (count == CNT_W'(DEPTH));
   assign push_acc = push && !full;
   assign pop_acc  = pop && !empty;
   assign head_len = slot[rd_ptr];

   always_ff @(posedge clk) begin
      if (push_acc) slot[wr_ptr] <= push_len;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push_acc) wr_ptr <= ptr_inc(wr_ptr);
         if (pop_acc)  rd_ptr <= ptr_inc(rd_ptr);
         case ({push_acc, pop_acc})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   assert_no_overflow_R12: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));
   assert_full_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop) |=> (count == CNT_W'(DEPTH)));
endmodule

// File: rtl/oq_irq_gen.sv
`timescale 1ns/1ps
module oq_irq_gen (
   input  logic clk,
   input  logic rst_n,
   input  logic irq_en,
   input  logic push_acc,
   input  logic empty,
   input  logic ctrl_rd,
   input  logic rd_done,
   output logic irq
);
   logic irq_src;
   logic first_msg, status_seen;

   assign first_msg   = push_acc && empty;      // 0 -> 1 transition
   assign status_seen = ctrl_rd || rd_done;     // explicit or appended read

   always_ff @(posedge clk) begin
      if (!rst_n)           irq_src <= 1'b0;
      else if (first_msg)   irq_src <= 1'b1;    // set wins over a clearing read
      else if (status_seen) irq_src <= 1'b0;
   end

   assign irq = irq_src && irq_en;

   assert_rise_from_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_src) |-> $past(empty));
   assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (status_seen && !(push_acc && empty)) |=> !irq_src);
   assert_nonempty_push_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_src && !empty) |=> !irq_src);
endmodule

// File: rtl/oq_read_check.sv
`timescale 1ns/1ps
module oq_read_check
   import oq_status_pkg::*;
#(
   parameter int LEN_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_done,
   input  logic [LEN_W:0]   rd_words,
   input  logic             empty,
   input  logic [LEN_W-1:0] head_len,
   output logic             pop,
   output oq_rd_err_t       err
);
   logic [LEN_W:0] need;
   oq_rd_err_t     err_d;

   assign need           = {1'b0, head_len} + 1'b1;   // payload plus status word
   assign pop            = rd_done && !empty;
   assign err_d.none     = rd_done && empty;
   assign err_d.short_rd = pop && (rd_words < need);

   always_ff @(posedge clk) begin
      if (!rst_n) err <= '0;
      else        err <= err_d;
   end

   assert_err_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(err.none && err.short_rd));
   assert_empty_read_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_done && empty) |=> err.none);
endmodule

// File: rtl/oq_status_ctl.sv
`timescale 1ns/1ps
module oq_status_ctl
   import oq_status_pkg::*;
#(
   parameter int DEPTH = 4,
   parameter int LEN_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             irq_en,
   input  logic             push_valid,
   input  logic [LEN_W-1:0] push_len,
   input  logic             rd_done,
   input  logic [LEN_W:0]   rd_words,
   input  logic             ctrl_rd,
   output logic             irq,
   output logic [31:0]      ctrl_word,
   output logic             err_no_item,
   output logic             err_short_read
);
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam int FLD_W = CTRL_W - LEN_W;

   if (LEN_W < 1 || LEN_W >= CTRL_W) begin : g_bad_len
      $error("oq_status_ctl: LEN_W must lie in 1..CTRL_W-1");
   end
   if (DEPTH < 1) begin : g_bad_depth
      $error("oq_status_ctl: DEPTH must be at least 1");
   end

   logic             push_acc, empty, pop;
   logic [LEN_W-1:0] head_len;
   logic [CNT_W-1:0] count;
   logic [FLD_W-1:0] cnt_fld;
   oq_rd_err_t       err;

   oq_len_fifo #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_fifo (
      .clk, .rst_n,
      .push     (push_valid),
      .push_len (push_len),
      .pop      (pop),
      .push_acc (push_acc),
      .head_len (head_len),
      .count    (count),
      .empty    (empty)
   );

   oq_irq_gen u_irq (
      .clk, .rst_n,
      .irq_en   (irq_en),
      .push_acc (push_acc),
      .empty    (empty),
      .ctrl_rd  (ctrl_rd),
      .rd_done  (rd_done),
      .irq      (irq)
   );

   oq_read_check #(.LEN_W(LEN_W)) u_chk (
      .clk, .rst_n,
      .rd_done  (rd_done),
      .rd_words (rd_words),
      .empty    (empty),
      .head_len (head_len),
      .pop      (pop),
      .err      (err)
   );

   if (CNT_W > FLD_W) begin : g_cnt_sat
      assign cnt_fld = (count > CNT_W'((1 << FLD_W) - 1)) ? '1 : count[FLD_W-1:0];
   end else begin : g_cnt_ext
      assign cnt_fld = FLD_W'(count);
   end

   assign ctrl_word      = {{(BUS_W - CTRL_W){1'b0}}, cnt_fld,
                            empty ? {LEN_W{1'b0}} : head_len};
   assign err_no_item    = err.none;
   assign err_short_read = err.short_rd;
endmodule

// File: tb/tb_oq_status_ctl.sv
`timescale 1ns/1ps
module tb_oq_status_ctl;
   localparam int DEPTH = 4;
   localparam int LEN_W = 12;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             irq_en = 1'b0;
   logic             push_valid = 1'b0;
   logic [LEN_W-1:0] push_len = '0;
   logic             rd_done = 1'b0;
   logic [LEN_W:0]   rd_words = '0;
   logic             ctrl_rd = 1'b0;
   logic             irq;
   logic [31:0]      ctrl_word;
   logic             err_no_item, err_short_read;

   int tests = 0, fails = 0;
   bit done = 1'b0;

   // bench model
   int m_q [DEPTH];
   int m_cnt = 0;
   bit m_src = 1'b0;

   always #4 clk = ~clk;

   oq_status_ctl #(.DEPTH(DEPTH), .LEN_W(LEN_W)) dut (
      .clk, .rst_n, .irq_en, .push_valid, .push_len, .rd_done, .rd_words,
      .ctrl_rd, .irq, .ctrl_word, .err_no_item, .err_short_read
   );

   task automatic check(input string req, input string what,
                        input longint act, input longint exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   function automatic longint exp_ctrl();
      longint c = (m_cnt > 15) ? 15 : m_cnt;
      return (c << 12) | ((m_cnt > 0) ? m_q[0] : 0);
   endfunction

   // one clock cycle with the given strobes; model update and output checks
   task automatic cyc(input string req, input bit p, input int len,
                      input bit r, input int words, input bit c);
      bit e_none, e_short, push_ok, popped;
      push_valid = p; push_len = LEN_W'(len);
      rd_done = r; rd_words = (LEN_W+1)'(words); ctrl_rd = c;
      e_none  = r && (m_cnt == 0);
      e_short = r && (m_cnt > 0) && (words < m_q[0] + 1);
      push_ok = p && (m_cnt < DEPTH);
      popped  = r && (m_cnt > 0);
      if (push_ok && m_cnt == 0) m_src = 1'b1;
      else if (r || c)           m_src = 1'b0;
      if (popped) begin
         for (int i = 0; i < DEPTH - 1; i++) m_q[i] = m_q[i+1];
         m_cnt--;
      end
      if (push_ok) begin
         m_q[m_cnt] = len;
         m_cnt++;
      end
      @(posedge clk);
      #1;
      push_valid = 1'b0; rd_done = 1'b0; ctrl_rd = 1'b0;
      check(req, "irq", irq, m_src && irq_en);
      check(req, "ctrl_word", ctrl_word, exp_ctrl());
      check(req, "err_no_item", err_no_item, e_none);
      check(req, "err_short_read", err_short_read, e_short);
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         tests++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      int lf;
      int lens [5];
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1 reset state
      check("R1", "irq", irq, 0);
      check("R1", "ctrl_word", ctrl_word, 0);
      check("R1", "err_no_item", err_no_item, 0);
      check("R1", "err_short_read", err_short_read, 0);

      irq_en = 1'b1;
      cyc("R2", 1, 5, 0, 0, 0);        // first message raises irq
      cyc("R3", 1, 9, 0, 0, 0);        // second push, irq stays from first
      cyc("R5", 0, 0, 0, 0, 1);        // explicit control read clears
      cyc("R3", 1, 3, 0, 0, 0);        // push while non-empty: no irq
      check("R3", "irq after non-empty push", irq, 0);
      cyc("R10", 0, 0, 1, 5, 0);       // len 5 needs 6: short
      cyc("R13", 0, 0, 1, 10, 0);      // len 9, exact 10
      cyc("R13", 0, 0, 1, 7, 0);       // len 3, over-read allowed
      cyc("R9", 0, 0, 1, 4, 0);        // empty read
      cyc("R9", 0, 0, 0, 0, 0);        // pulse gone
      cyc("R11", 1, 12, 0, 0, 0);      // re-raise after drain
      check("R11", "irq re-raised", irq, 1);
      cyc("R6", 0, 0, 1, 13, 0);       // appended status clears
      check("R6", "irq after packet read", irq, 0);

      // fill then overflow
      for (int i = 0; i < DEPTH; i++) cyc("R12", 1, 100 + i, 0, 0, 0);
      cyc("R12", 1, 777, 0, 0, 0);     // ignored
      check("R12", "count field full", ctrl_word[15:12], DEPTH);
      for (int i = 0; i < DEPTH; i++) cyc("R13", 0, 0, 1, 101 + i, 0);
      check("R12", "drained", ctrl_word, 0);

      // mask
      irq_en = 1'b0;
      cyc("R4", 1, 8, 0, 0, 0);
      check("R4", "irq masked", irq, 0);
      irq_en = 1'b1;
      #1 check("R4", "latched source shown", irq, 1);
      cyc("R6", 0, 0, 1, 9, 0);

      // same-cycle set and clear
      cyc("R14", 1, 2, 0, 0, 1);
      check("R14", "irq set wins", irq, 1);
      cyc("R6", 0, 0, 1, 3, 0);
      cyc("R14", 1, 6, 1, 1, 0);       // empty read plus push
      check("R14", "irq set wins over rd_done", irq, 1);
      cyc("R10", 0, 0, 1, 7, 0);

      // length boundary sweep
      lens = '{0, 1, 2, 7, 4095};
      foreach (lens[k])
         for (int d = -1; d <= 2; d++) begin
            cyc("R7", 1, lens[k], 0, 0, 0);
            cyc("R10", 0, 0, 1, (lens[k] + d < 0) ? 0 : lens[k] + d, 0);
         end
      check("R8", "upper half", ctrl_word[31:16], 0);

      // pseudo-random mix
      lf = 32'h1ACE5;
      for (int n = 0; n < 3000; n++) begin
         lf = (lf >> 1) ^ ((lf & 1) ? 32'h80200003 : 0);
         irq_en = lf[9];
         cyc("R8", lf[0] & lf[1], lf[21:10], lf[2] & lf[3], lf[12:0] & 13'h00F,
             lf[4] & lf[5] & lf[6]);
         check("R8", "upper half", ctrl_word[31:16], 0);
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule